// File: doc/BRIEF.md
# Memory Region Permission Arbiter

This block decides whether a single memory access may proceed. It is given the access's first byte address, its size, the read/write/execute rights it asks for and the current privilege level. It also receives a table of protection entries, with a decoded inclusive low and high bound, a matching mode, three permission bits and a lock flag for each. From these it returns one allow/deny bit in the same cycle, with no state of its own. Turning raw region registers into bounds is done upstream, and acting on a deny (trapping) is done downstream.

Each entry tests two points against its range: the first byte and the point `size` bytes beyond it. Entries are scanned from index 0 upward, and the first entry that either point falls into settles the outcome. When only one of the two points falls into that entry, the access straddles a boundary and is refused. When both points fall inside, the entry's mode and permission bits decide. If no entry is touched, the privilege level alone decides.

Top module: `pmp_perm_check`

## Requirements
- R1: When every entry's mode field is the off code (2'b00), every access is allowed, whatever the bounds, address, size, request or privilege.
- R2: Entries are prioritised by index, and the entry with the lowest index that contains either checked point alone decides the result. Entries with higher indices are ignored.
- R3: The two checked points are `acc_addr` and `acc_addr + acc_size` (modulo 2^ADDR_W). Each is compared with the entry's bounds inclusively at both ends.
- R4: When exactly one of the two points lies within the deciding entry, the access is denied. This holds even if that entry's mode is off.
- R5: When both points lie within the deciding entry and its mode is off (2'b00), and at least one entry is active, the access is allowed regardless of the request.
- R6: Below machine privilege, a full match on an active entry grants exactly that entry's permission bits, with bit 0 = read, bit 1 = write and bit 2 = execute.
- R7: At machine privilege (`priv_mode` = 2'b11), a full match on an active unlocked entry grants read, write and execute.
- R8: At machine privilege, a full match on an active locked entry grants only that entry's permission bits.
- R9: A matched access is allowed only if every requested bit is in the granted set. An empty request (3'b000) is always allowed on a full match.
- R10: When at least one entry is active and no entry contains either point, the access is allowed at machine privilege and denied at every other privilege code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | ADDR_W | First byte address of the access |
| acc_size | input | ADDR_W | Offset added to the address to form the second checked point |
| acc_req | input | 3 | Requested rights: bit 0 read, bit 1 write, bit 2 execute |
| priv_mode | input | 2 | Current privilege code; 2'b11 is machine |
| ent_lo | input | NUM_ENTRIES*ADDR_W | Inclusive low bound, entry i at [i*ADDR_W +: ADDR_W] |
| ent_hi | input | NUM_ENTRIES*ADDR_W | Inclusive high bound, same packing |
| ent_mode | input | NUM_ENTRIES*2 | Matching mode per entry, 2'b00 = off |
| ent_perm | input | NUM_ENTRIES*3 | Permission bits per entry, same order as acc_req |
| ent_lock | input | NUM_ENTRIES | Lock flag per entry |
| acc_allow | output | 1 | 1 = access permitted, 0 = refused |

## Verification
The boundary test and the priority scan resolve together. An access can straddle the edge of a low-index entry while sitting wholly inside a larger, more permissive entry with a higher index. Vectors of this kind are driven to confirm that the straddle on the lower entry forces a deny and the later entry is never consulted. The bench also places the two points exactly on an inclusive bound and one byte past it, and runs the machine-privilege override against locked and unlocked entries, so that a fault in the lock path or an off-by-one bound flips a checked result.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  localparam int PERM_W = 3;
  localparam int MODE_W = 2;

  localparam logic [MODE_W-1:0] MODE_OFF     = 2'b00;
  localparam logic [1:0]        PRIV_MACHINE = 2'b11;

  // Per-entry outcome handed to the priority stage.
  typedef struct packed {
    logic touch;    // either checked point falls in this entry
    logic verdict;  // outcome if this entry is the deciding one
  } entry_res_t;

endpackage

// File: rtl/pmp_entry_eval.sv
module pmp_entry_eval
  import pmp_chk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] first_pt,
  input  logic [ADDR_W-1:0] second_pt,
  input  logic [ADDR_W-1:0] lo_bound,
  input  logic [ADDR_W-1:0] hi_bound,
  input  logic [MODE_W-1:0] mode,
  input  logic [PERM_W-1:0] perm,
  input  logic              locked,
  input  logic [PERM_W-1:0] req,
  input  logic              is_machine,
  output logic              active,
  output entry_res_t        res
);

  logic              in_first;
  logic              in_second;
  logic              straddle;
  logic [PERM_W-1:0] granted;

  always_comb begin
    in_first  = (first_pt  >= lo_bound) && (first_pt  <= hi_bound);
    in_second = (second_pt >= lo_bound) && (second_pt <= hi_bound);
    straddle  = in_first ^ in_second;
    active    = (mode != MODE_OFF);

    if (is_machine && !locked) begin
      granted = '1;
    end else begin
      granted = perm;
    end

    res.touch = in_first | in_second;
    if (straddle) begin
      res.verdict = 1'b0;
    end else if (!active) begin
      res.verdict = 1'b1;
    end else begin
      res.verdict = ((req & granted) == req);
    end
  end

endmodule

// File: rtl/pmp_first_hit.sv
module pmp_first_hit
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  entry_res_t res [NUM_ENTRIES],
  output logic       hit,
  output logic       verdict
);

  // Scan from the top down so the lowest index is assigned last and wins.
  always_comb begin
    hit     = 1'b0;
    verdict = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (res[i].touch) begin
        hit     = 1'b1;
        verdict = res[i].verdict;
      end
    end
  end

endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32
) (
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [ADDR_W-1:0]             acc_size,
  input  logic [PERM_W-1:0]             acc_req,
  input  logic [1:0]                    priv_mode,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_lo,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_hi,
  input  logic [NUM_ENTRIES*MODE_W-1:0] ent_mode,
  input  logic [NUM_ENTRIES*PERM_W-1:0] ent_perm,
  input  logic [NUM_ENTRIES-1:0]        ent_lock,
  output logic                          acc_allow
);

  logic [ADDR_W-1:0]      second_pt;
  logic                   is_machine;
  logic [NUM_ENTRIES-1:0] ent_active;
  entry_res_t             ent_res [NUM_ENTRIES];
  logic                   any_hit;
  logic                   hit_verdict;

  assign second_pt  = acc_addr + acc_size;
  assign is_machine = (priv_mode == PRIV_MACHINE);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    pmp_entry_eval #(
      .ADDR_W(ADDR_W)
    ) u_eval (
      .first_pt  (acc_addr),
      .second_pt (second_pt),
      .lo_bound  (ent_lo[g*ADDR_W +: ADDR_W]),
      .hi_bound  (ent_hi[g*ADDR_W +: ADDR_W]),
      .mode      (ent_mode[g*MODE_W +: MODE_W]),
      .perm      (ent_perm[g*PERM_W +: PERM_W]),
      .locked    (ent_lock[g]),
      .req       (acc_req),
      .is_machine(is_machine),
      .active    (ent_active[g]),
      .res       (ent_res[g])
    );
  end

  pmp_first_hit #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_pick (
    .res    (ent_res),
    .hit    (any_hit),
    .verdict(hit_verdict)
  );

  always_comb begin
    if (ent_active == '0) begin
      acc_allow = 1'b1;
    end else if (any_hit) begin
      acc_allow = hit_verdict;
    end else begin
      acc_allow = is_machine;
    end
  end

endmodule

// File: rtl/pmp_perm_check_sva.sv
module pmp_perm_check_sva
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32
) (
  input logic [ADDR_W-1:0]             acc_addr,
  input logic [ADDR_W-1:0]             acc_size,
  input logic [PERM_W-1:0]             acc_req,
  input logic [1:0]                    priv_mode,
  input logic [NUM_ENTRIES*ADDR_W-1:0] ent_lo,
  input logic [NUM_ENTRIES*ADDR_W-1:0] ent_hi,
  input logic [NUM_ENTRIES*MODE_W-1:0] ent_mode,
  input logic [NUM_ENTRIES*PERM_W-1:0] ent_perm,
  input logic [NUM_ENTRIES-1:0]        ent_lock,
  input logic                          acc_allow
);

  logic [ADDR_W-1:0] pt_b;
  logic              some_active;
  logic              some_touch;
  logic              z_a;
  logic              z_b;
  logic              z_full;
  logic              z_on;

  always_comb begin
    pt_b        = acc_addr + acc_size;
    some_active = 1'b0;
    some_touch  = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (ent_mode[i*MODE_W +: MODE_W] != MODE_OFF) some_active = 1'b1;
      if (((acc_addr >= ent_lo[i*ADDR_W +: ADDR_W]) && (acc_addr <= ent_hi[i*ADDR_W +: ADDR_W])) ||
          ((pt_b     >= ent_lo[i*ADDR_W +: ADDR_W]) && (pt_b     <= ent_hi[i*ADDR_W +: ADDR_W])))
        some_touch = 1'b1;
    end
    z_a    = (acc_addr >= ent_lo[ADDR_W-1:0]) && (acc_addr <= ent_hi[ADDR_W-1:0]);
    z_b    = (pt_b >= ent_lo[ADDR_W-1:0]) && (pt_b <= ent_hi[ADDR_W-1:0]);
    z_full = z_a && z_b;
    z_on   = (ent_mode[MODE_W-1:0] != MODE_OFF);
  end

  always_comb begin
    if (!some_active) begin
      p_all_off_allow_r1: assert (acc_allow) else $error("R1 violated");
    end
    if (some_active && (z_a ^ z_b)) begin
      p_straddle_deny_r4: assert (!acc_allow) else $error("R4 violated");
    end
    if (some_active && z_full && !z_on) begin
      p_off_full_allow_r5: assert (acc_allow) else $error("R5 violated");
    end
    if (z_full && z_on && (priv_mode != PRIV_MACHINE)) begin
      p_user_perm_r6: assert (acc_allow == ((acc_req & ent_perm[PERM_W-1:0]) == acc_req))
        else $error("R6 violated");
    end
    if (z_full && z_on && (priv_mode == PRIV_MACHINE) && !ent_lock[0]) begin
      p_mach_bypass_r7: assert (acc_allow) else $error("R7 violated");
    end
    if (some_active && !some_touch) begin
      p_no_match_r10: assert (acc_allow == (priv_mode == PRIV_MACHINE)) else $error("R10 violated");
    end
  end

endmodule

bind pmp_perm_check pmp_perm_check_sva #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .ADDR_W     (ADDR_W)
) u_sva (
  .acc_addr (acc_addr),
  .acc_size (acc_size),
  .acc_req  (acc_req),
  .priv_mode(priv_mode),
  .ent_lo   (ent_lo),
  .ent_hi   (ent_hi),
  .ent_mode (ent_mode),
  .ent_perm (ent_perm),
  .ent_lock (ent_lock),
  .acc_allow(acc_allow)
);

// File: tb/pmp_perm_check_tb.sv
module pmp_perm_check_tb;

  localparam int N  = 4;
  localparam int AW = 16;
  localparam int VW = AW + AW + 3 + 2 + 1;
  localparam int NV = 18;

  // {addr, size, request, privilege, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'h1010, 16'd4, 3'b001, 2'b00, 1'b1},  // R6 read granted by entry 0
    {16'h1010, 16'd4, 3'b010, 2'b00, 1'b0},  // R2 entry 0 refuses write though entry 1 allows
    {16'h1200, 16'd4, 3'b010, 2'b01, 1'b1},  // R2 only entry 1 touched, RW
    {16'h10FC, 16'd8, 3'b001, 2'b00, 1'b0},  // R4 straddles entry 0, inside entry 1
    {16'h10FC, 16'd3, 3'b001, 2'b00, 1'b1},  // R3 second point on inclusive high bound
    {16'h10FC, 16'd4, 3'b001, 2'b00, 1'b0},  // R3 second point one past high bound
    {16'h1010, 16'd4, 3'b010, 2'b11, 1'b1},  // R7 machine unlocked override
    {16'h1010, 16'd4, 3'b111, 2'b11, 1'b1},  // R7 machine gets RWX
    {16'h4010, 16'd4, 3'b001, 2'b11, 1'b0},  // R8 locked entry binds machine
    {16'h4010, 16'd4, 3'b100, 2'b11, 1'b1},  // R8 locked entry exec bit
    {16'h4010, 16'd4, 3'b100, 2'b00, 1'b1},  // R6 exec below machine
    {16'h6010, 16'd4, 3'b111, 2'b00, 1'b1},  // R5 full match on off entry
    {16'h8000, 16'd4, 3'b001, 2'b00, 1'b0},  // R10 no match, user
    {16'h8000, 16'd4, 3'b001, 2'b11, 1'b1},  // R10 no match, machine
    {16'h4010, 16'd4, 3'b000, 2'b00, 1'b1},  // R9 empty request
    {16'h4010, 16'd4, 3'b101, 2'b00, 1'b0},  // R9 read+exec, only exec held
    {16'h5FFE, 16'd4, 3'b001, 2'b00, 1'b0},  // R4 straddles low bound of off entry
    {16'h0FFF, 16'd1, 3'b001, 2'b00, 1'b0}   // R3 first point one below low bound
  };

  logic clk;
  logic rst_n;

  logic [AW-1:0]   acc_addr;
  logic [AW-1:0]   acc_size;
  logic [2:0]      acc_req;
  logic [1:0]      priv_mode;
  logic [N*AW-1:0] ent_lo;
  logic [N*AW-1:0] ent_hi;
  logic [N*2-1:0]  ent_mode;
  logic [N*3-1:0]  ent_perm;
  logic [N-1:0]    ent_lock;
  logic            acc_allow;

  int n_cmp;
  int n_bad;
  bit done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  pmp_perm_check #(
    .NUM_ENTRIES(N),
    .ADDR_W     (AW)
  ) u_dut (
    .acc_addr (acc_addr),
    .acc_size (acc_size),
    .acc_req  (acc_req),
    .priv_mode(priv_mode),
    .ent_lo   (ent_lo),
    .ent_hi   (ent_hi),
    .ent_mode (ent_mode),
    .ent_perm (ent_perm),
    .ent_lock (ent_lock),
    .acc_allow(acc_allow)
  );

  task automatic load_table(input logic [N*2-1:0] modes);
    ent_lo   = {16'h6000, 16'h4000, 16'h1000, 16'h1000};
    ent_hi   = {16'h6FFF, 16'h4FFF, 16'h1FFF, 16'h10FF};
    ent_mode = modes;
    ent_perm = {3'b000, 3'b100, 3'b011, 3'b001};
    ent_lock = 4'b0100;
  endtask

  task automatic apply(input logic [AW-1:0] a, input logic [AW-1:0] s,
                       input logic [2:0] r, input logic [1:0] p,
                       input logic exp, input string tag);
    @(posedge clk);
    acc_addr  = a;
    acc_size  = s;
    acc_req   = r;
    priv_mode = p;
    @(negedge clk);
    n_cmp++;
    if (acc_allow !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h size=%0d req=%b priv=%b actual=%b expected=%b",
               tag, a, s, r, p, acc_allow, exp);
    end
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    acc_addr  = '0;
    acc_size  = '0;
    acc_req   = '0;
    priv_mode = '0;
    ent_lo    = '0;
    ent_hi    = '0;
    ent_mode  = '0;
    ent_perm  = '0;
    ent_lock  = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all inputs zero, no active entry -> allow (R1)
    @(negedge clk);
    n_cmp++;
    if (acc_allow !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 idle actual=%b expected=1", acc_allow);
    end

    // Vector table with entries 0..2 active, entry 3 off
    load_table({2'b00, 2'b10, 2'b01, 2'b11});
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][VW-1 -: AW], VEC[v][VW-AW-1 -: AW], VEC[v][5:3],
            VEC[v][2:1], VEC[v][0], $sformatf("vector %0d", v));
    end

    // Directed: second point wraps past the top of the address space (R3)
    apply(16'hFFFE, 16'd4, 3'b001, 2'b00, 1'b0, "R3 wrap no match");

    // Directed: every entry off -> allowed even on straddle and no match (R1)
    load_table(8'h00);
    apply(16'h10FC, 16'd8, 3'b111, 2'b00, 1'b1, "R1 straddle with all off");
    apply(16'h8000, 16'd4, 3'b111, 2'b01, 1'b1, "R1 no match with all off");

    // Directed: unlock entry 2, machine now bypasses its bits (R7)
    load_table({2'b00, 2'b10, 2'b01, 2'b11});
    ent_lock = 4'b0000;
    apply(16'h4010, 16'd4, 3'b011, 2'b11, 1'b1, "R7 unlocked machine");
    // Supervisor code still limited by entry bits (R6)
    apply(16'h4010, 16'd4, 3'b001, 2'b01, 1'b0, "R6 supervisor limited");
    // Privilege code 2'b10 is not machine: no match denied (R10)
    apply(16'h8000, 16'd4, 3'b001, 2'b10, 1'b0, "R10 code 10 not machine");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule